// File: doc/BRIEF.md
# Ping-Pong Byte Buffer with Transfer Counter

This block sits between a 16-bit processor port and a byte-wide bus handshake engine. It holds two equal byte banks. At any moment one bank faces the processor, which writes or reads whole halfwords. The other bank faces the handshake engine, which moves one byte per strobe. A flip command swaps the roles of the two banks. Software can then fill or drain one bank while the engine works on the other.

The engine moves a bounded number of bytes. Software writes a 16-bit count one byte at a time, high half and low half, and then fires an arm strobe. The block caps the count at the bank depth. It then accepts exactly that many byte strobes and raises a completion flag. Moving a single byte uses the same mechanism with a count of one. Status outputs show whether the processor-side bank is empty or full, and whether the engine-side bank is empty.

Top module: `pingpong_fifo`

## Requirements
- R1: After reset both banks are empty (`proc_empty`=1, `alt_empty`=1, `proc_full`=0), `done`=0, `flip_err`=0, and bank 0 faces the processor.
- R2: A processor write stores `cpu_wdata[7:0]` first and `cpu_wdata[15:8]` second. When that bank faces the bus and `bus_rx`=0, `bus_rdata` shows the low byte first and each accepted strobe advances by one byte.
- R3: With `bus_rx`=1, each accepted strobe stores `bus_wdata`. A processor read of that bank then presents the first byte in `cpu_rdata[7:0]` and the second byte in `cpu_rdata[15:8]`.
- R4: `cnt_hi_wr` and `cnt_lo_wr` load the upper and lower count bytes from `cnt_byte`. `cnt_arm` clears `done`, and `done` rises on the clock edge that accepts the last counted byte. Arming a count of 0 sets `done` at once.
- R5: An armed count larger than DEPTH is treated as DEPTH.
- R6: `flip` exchanges the two banks when no count is pending. The status outputs then describe the newly assigned banks.
- R7: A `flip` while a count is pending leaves the banks unchanged and sets `flip_err`. The next `cnt_arm` clears `flip_err`.
- R8: A processor read of a bank that holds exactly one byte returns that byte in `cpu_rdata[7:0]` and leaves the bank empty.
- R9: A bus strobe is ignored when no count is pending, when transmitting from an empty bank, or when receiving into a full bank. An ignored strobe does not advance the count.
- R10: A processor write is ignored when fewer than two bytes are free. A processor read of an empty bank is ignored. No bank ever holds more than DEPTH bytes.
- R11: Arming a count of 1 moves exactly one byte and then sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset; empties both banks and selects bank 0 |
| cpu_wr | input | 1 | Processor halfword write strobe |
| cpu_wdata | input | 16 | Processor write halfword |
| cpu_rd | input | 1 | Processor halfword read strobe (pops the halfword shown) |
| cpu_rdata | output | 16 | Halfword at the head of the processor-side bank |
| cnt_hi_wr | input | 1 | Load upper count byte |
| cnt_lo_wr | input | 1 | Load lower count byte |
| cnt_byte | input | 8 | Count byte value |
| cnt_arm | input | 1 | Start a transfer of the loaded count |
| flip | input | 1 | Swap the banks |
| bus_rx | input | 1 | 1: engine writes bytes into its bank; 0: engine reads bytes out |
| bus_stb | input | 1 | Move one byte on the engine side |
| bus_wdata | input | 8 | Byte from the engine |
| bus_rdata | output | 8 | Byte at the head of the engine-side bank |
| proc_empty | output | 1 | Processor-side bank holds no bytes |
| proc_full | output | 1 | Processor-side bank holds DEPTH bytes |
| alt_empty | output | 1 | Engine-side bank holds no bytes |
| done | output | 1 | Armed count fully moved |
| flip_err | output | 1 | A flip was refused because a count was pending |

## Verification
The bench targets several corner cases, and each one exposes a specific fault.

- **Odd byte count.** The last halfword read must empty the bank. A design that always advanced by two would leave its pointers crossed and report the bank as non-empty forever.
- **Count above the bank depth.** A design without the cap would never raise `done` after DEPTH bytes.
- **Flip while a count is pending.** A design that swapped anyway would show the other bank's status at once.
- **Strobes that cannot move a byte.** A design that decremented on them would finish early.
- **Byte order.** Swapped halves would show up on every table vector.
- **Overfull writes and empty reads.** A design that let these through would corrupt the data that is read back afterwards.

// File: rtl/pingpong_fifo.sv
module pingpong_fifo #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_wdata,
  input  logic        cpu_rd,
  output logic [15:0] cpu_rdata,
  input  logic        cnt_hi_wr,
  input  logic        cnt_lo_wr,
  input  logic [7:0]  cnt_byte,
  input  logic        cnt_arm,
  input  logic        flip,
  input  logic        bus_rx,
  input  logic        bus_stb,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        proc_empty,
  output logic        proc_full,
  output logic        alt_empty,
  output logic        done,
  output logic        flip_err
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULLV = PW'(DEPTH);
  localparam logic [PW-1:0] ROOMV = PW'(DEPTH - 2);

  logic [7:0]    mem [2][DEPTH];
  logic [PW-1:0] wp [2];
  logic [PW-1:0] rp [2];
  logic [PW-1:0] lvl [2];
  logic          sel;
  logic [15:0]   cnt_ld;
  logic [CW-1:0] left;
  logic [CW-1:0] lim;
  logic          p, b, busy, do_cw, do_cr, do_bx;
  logic [AW-1:0] pr, bw, br, pw;

  always_comb
    for (int k = 0; k < 2; k++) lvl[k] = wp[k] - rp[k];

  assign p     = sel;
  assign b     = ~sel;
  assign busy  = left != '0;
  assign pr    = rp[p][AW-1:0];
  assign pw    = wp[p][AW-1:0];
  assign br    = rp[b][AW-1:0];
  assign bw    = wp[b][AW-1:0];
  assign lim   = (cnt_ld > 16'(DEPTH)) ? CW'(DEPTH) : CW'(cnt_ld);
  assign do_cw = cpu_wr && (lvl[p] <= ROOMV);
  assign do_cr = cpu_rd && (lvl[p] != '0);
  assign do_bx = bus_stb && busy && (bus_rx ? (lvl[b] != FULLV) : (lvl[b] != '0));

  assign cpu_rdata  = {mem[p][pr + AW'(1)], mem[p][pr]};
  assign bus_rdata  = mem[b][br];
  assign proc_empty = lvl[p] == '0;
  assign proc_full  = lvl[p] == FULLV;
  assign alt_empty  = lvl[b] == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      wp[0]    <= '0;
      wp[1]    <= '0;
      rp[0]    <= '0;
      rp[1]    <= '0;
      cnt_ld   <= '0;
      left     <= '0;
      done     <= 1'b0;
      flip_err <= 1'b0;
    end else begin
      if (cnt_hi_wr) cnt_ld[15:8] <= cnt_byte;
      if (cnt_lo_wr) cnt_ld[7:0]  <= cnt_byte;

      if (cnt_arm) begin
        left     <= lim;
        done     <= lim == '0;
        flip_err <= 1'b0;
      end else if (do_bx) begin
        left <= left - CW'(1);
        if (left == CW'(1)) done <= 1'b1;
      end

      if (flip) begin
        if (busy) begin
          if (!cnt_arm) flip_err <= 1'b1;
        end else begin
          sel <= ~sel;
        end
      end

      if (do_cw) begin
        mem[p][pw]          <= cpu_wdata[7:0];
        mem[p][pw + AW'(1)] <= cpu_wdata[15:8];
        wp[p]               <= wp[p] + PW'(2);
      end
      if (do_cr) rp[p] <= (lvl[p] == PW'(1)) ? wp[p] : rp[p] + PW'(2);

      if (do_bx) begin
        if (bus_rx) begin
          mem[b][bw] <= bus_wdata;
          wp[b]      <= wp[b] + PW'(1);
        end else begin
          rp[b] <= rp[b] + PW'(1);
        end
      end
    end
  end

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    left <= CW'(DEPTH));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_arm_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_arm && lim != '0) |=> (!done && busy));
  assert_flip_refused_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flip && busy && !cnt_arm) |=> ($stable(sel) && flip_err));
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl[0] <= FULLV) && (lvl[1] <= FULLV));
  assert_ignored_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_arm && !do_bx) |=> $stable(left));
endmodule

// File: tb/pingpong_fifo_bench.sv
module pingpong_fifo_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cpu_wr = 0, cpu_rd = 0, cnt_hi_wr = 0, cnt_lo_wr = 0, cnt_arm = 0;
  logic        flip = 0, bus_rx = 0, bus_stb = 0;
  logic [15:0] cpu_wdata = '0;
  logic [7:0]  cnt_byte = '0, bus_wdata = '0;
  logic [15:0] cpu_rdata;
  logic [7:0]  bus_rdata;
  logic        proc_empty, proc_full, alt_empty, done, flip_err;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  pingpong_fifo #(.DEPTH(16)) u_pingpong_fifo (.*);

  // {halfword written, first byte expected on bus, second byte expected}
  localparam logic [31:0] VEC [6] = '{
    32'h1234_34_12, 32'hA55A_5A_A5, 32'h00FF_FF_00,
    32'hFF00_00_FF, 32'h8001_01_80, 32'hC3E7_E7_C3};

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cw(input logic [15:0] d);
    @(negedge clk); cpu_wr = 1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask
  task automatic cr;
    @(negedge clk); cpu_rd = 1;
    @(negedge clk); cpu_rd = 0;
  endtask
  task automatic do_flip;
    @(negedge clk); flip = 1;
    @(negedge clk); flip = 0;
  endtask
  task automatic arm(input logic [15:0] n);
    @(negedge clk); cnt_hi_wr = 1; cnt_byte = n[15:8];
    @(negedge clk); cnt_hi_wr = 0; cnt_lo_wr = 1; cnt_byte = n[7:0];
    @(negedge clk); cnt_lo_wr = 0; cnt_arm = 1;
    @(negedge clk); cnt_arm = 0;
  endtask
  task automatic rx(input logic [7:0] d);
    @(negedge clk); bus_rx = 1; bus_wdata = d; bus_stb = 1;
    @(negedge clk); bus_stb = 0;
  endtask
  task automatic tx;
    @(negedge clk); bus_rx = 0; bus_stb = 1;
    @(negedge clk); bus_stb = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 proc_empty", proc_empty, 1);
    chk("R1 alt_empty", alt_empty, 1);
    chk("R1 proc_full", proc_full, 0);
    chk("R1 done", done, 0);
    chk("R1 flip_err", flip_err, 0);

    for (int i = 0; i < 6; i++) begin
      cw(VEC[i][31:16]);
      do_flip;
      chk("R6 alt_empty after flip", alt_empty, 0);
      arm(16'd2);
      chk("R4 done cleared", done, 0);
      chk("R2 first byte", bus_rdata, VEC[i][15:8]);
      tx;
      chk("R2 second byte", bus_rdata, VEC[i][7:0]);
      tx;
      chk("R4 done after 2", done, 1);
    end

    rx(8'h55);
    chk("R9 idle strobe ignored", alt_empty, 1);

    arm(16'd3);
    rx(8'hA1); rx(8'hB2);
    chk("R4 done early", done, 0);
    rx(8'hC3);
    chk("R4 done after 3", done, 1);
    do_flip;
    chk("R6 proc_empty", proc_empty, 0);
    chk("R6 alt_empty", alt_empty, 1);
    chk("R3 packed halfword", cpu_rdata, 16'hB2A1);
    cr;
    chk("R8 last byte", cpu_rdata[7:0], 8'hC3);
    cr;
    chk("R8 bank empty", proc_empty, 1);

    cw(16'h7788);
    arm(16'd2);
    do_flip;
    chk("R7 flip_err", flip_err, 1);
    chk("R7 banks kept", proc_empty, 0);
    chk("R7 alt kept", alt_empty, 1);
    tx;
    chk("R9 tx from empty ignored", done, 0);
    arm(16'd0);
    chk("R4 zero count", done, 1);
    chk("R7 err cleared", flip_err, 0);
    do_flip;
    chk("R6 swapped proc", proc_empty, 1);
    chk("R6 swapped alt", alt_empty, 0);
    arm(16'd2);
    chk("R2 low first", bus_rdata, 8'h88);
    tx;
    chk("R2 high second", bus_rdata, 8'h77);
    tx;
    chk("R4 done", done, 1);

    arm(16'h0100);
    for (int i = 0; i < 15; i++) rx(8'(i));
    chk("R5 not yet done", done, 0);
    rx(8'd15);
    chk("R5 capped done", done, 1);
    rx(8'hEE);
    do_flip;
    chk("R5 proc_full", proc_full, 1);
    for (int i = 0; i < 8; i++) begin
      chk("R5 data", cpu_rdata, {8'(2*i+1), 8'(2*i)});
      cr;
    end
    chk("R10 drained", proc_empty, 1);

    for (int i = 0; i < 8; i++) cw(16'hA000 + 16'(i));
    chk("R10 full", proc_full, 1);
    cw(16'hFFFF);
    for (int i = 0; i < 8; i++) begin
      chk("R10 readback", cpu_rdata, 16'hA000 + 16'(i));
      cr;
    end
    chk("R10 empty", proc_empty, 1);
    cr;
    cw(16'h1111);
    chk("R10 empty read ignored", cpu_rdata, 16'h1111);
    cr;

    cw(16'h00EE);
    do_flip;
    arm(16'd1);
    chk("R11 single byte", bus_rdata, 8'hEE);
    tx;
    chk("R11 done", done, 1);
    chk("R11 leftover byte", alt_empty, 0);

    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R1 reset alt_empty", alt_empty, 1);
    chk("R1 reset proc_empty", proc_empty, 1);
    chk("R1 reset done", done, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule